// File: doc/BRIEF.md
# Coincidence and Energy Hit Filter

This block sits on one time-ordered stream of detector hits and reduces its volume before the data goes further. Each incoming 48-bit hit has its amplitude scaled by a per-channel gain factor. Consecutive hits from one chip that lie close in time are merged into one cluster record carrying the summed energy. Clusters whose energy falls outside a programmable window are removed. A cluster is passed on only if a cluster from a different chip lies within a programmable coincidence window of it. Timeout marker words carry time forward but never leave the block.

Coincidence is decided in streaming form. Every surviving cluster waits in an eight-entry window buffer until the newest incoming time has moved more than the coincidence window past it. Only then is its status final. Coincident clusters leave in timestamp order, and lone clusters are dropped. A timeout marker closes any open cluster and makes the buffer release what has become final, so a quiet stream is flushed by sending one marker with a later time.

The cluster builder runs three states. COLLECT accepts words: a joining hit adds to the open cluster, the first hit opens one, a hit that does not join goes to EMIT, and a marker goes to EMIT when a cluster is open or to MARK when none is. EMIT offers the cluster, or skips it when the energy cut fails, then goes to MARK when a marker is pending or back to COLLECT with the waiting hit as the new cluster. MARK passes the marker to the window and returns to COLLECT. The window unit runs four states. IDLE takes an event. MATCH compares it with every buffered entry. RETIRE releases or discards final entries from the oldest end until the oldest is no longer final. INSERT stores the new cluster, or ignores a marker, and returns to IDLE.

Top module: `coinc_energy_filter`

## Requirements
- R1: Input and output words share one layout: bits 47:24 timestamp, bits 23:20 chip number, bits 19:16 channel, bits 15:7 amplitude, bits 6:0 flags. Flags bit 0 set marks a timeout marker.
- R2: The corrected amplitude is (amplitude × gain) / 64, truncated, and saturated at 511. The gain is read from a 16-entry table indexed by the channel. A table entry is written on a clock edge with cfg_we high, and every entry resets to 64, which is unity gain.
- R3: A hit joins the open cluster when it has the same chip number and its timestamp is at most CLUSTER_WIN (default 4) ticks after the cluster's first hit. A cluster becomes one record with the timestamp, ID and flags of its first hit and the sum of the corrected amplitudes, saturated at 511.
- R4: A cluster whose energy is below e_lo or above e_hi is discarded. Both bounds are inclusive.
- R5: Two clusters from different chips whose timestamps differ by at most coinc_win ticks are both output. A cluster with no such partner is discarded, and clusters from the same chip never pair.
- R6: A timeout marker is never output. It closes any open cluster and advances the time used for release decisions.
- R7: A cluster leaves only after an event arrives whose timestamp exceeds the cluster's timestamp by more than coinc_win. Outputs appear in timestamp order.
- R8: The window buffer holds 8 clusters. Inserting into a full buffer discards the oldest entry and increments drop_count.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.
- R10: After reset, out_valid is 0, drop_count is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input hit word valid |
| in_ready | output | 1 | Block accepts an input word |
| in_data | input | 48 | Input hit word |
| out_valid | output | 1 | Output cluster word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | 48 | Accepted cluster word |
| cfg_we | input | 1 | Gain table write strobe |
| cfg_addr | input | 4 | Gain table channel index |
| cfg_gain | input | 8 | Gain factor, 64 means unity |
| coinc_win | input | 8 | Coincidence window in ticks |
| e_lo | input | 9 | Lower energy bound, inclusive |
| e_hi | input | 9 | Upper energy bound, inclusive |
| drop_count | output | 16 | Count of clusters lost to buffer overflow |

## Verification
On every cycle the assertions check four things: a stalled output word is held, no marker word ever reaches the output, every released entry is already final against the newest time, and each cluster handed to the window meets the energy bounds. They also check that the buffer occupancy never exceeds its depth, that drop_count moves only on an insert into a full buffer, and that merging a hit never lowers a cluster sum. Only the directed scenarios can show the values that come out. These cover gain scaling and saturation, which clusters pair at the exact window edge, clusters that are separated by a marker, the summed energies, and which entry an overflow evicts.

// File: rtl/hitflt_pkg.sv
package hitflt_pkg;

    localparam int TS_W    = 24;
    localparam int ID_W    = 8;
    localparam int AMP_W   = 9;
    localparam int FLAG_W  = 7;
    localparam int CHIP_W  = 4;
    localparam int CH_W    = ID_W - CHIP_W;
    localparam int HIT_W   = TS_W + ID_W + AMP_W + FLAG_W;
    localparam int AMP_MAX = (1 << AMP_W) - 1;

    typedef struct packed {
        logic [TS_W-1:0]   ts;
        logic [ID_W-1:0]   id;
        logic [AMP_W-1:0]  amp;
        logic [FLAG_W-1:0] flags;
    } hit_t;

endpackage

// File: rtl/hitflt_gain_table.sv
module hitflt_gain_table
    import hitflt_pkg::*;
#(
    parameter int N_CH   = 16,
    parameter int GAIN_W = 8,
    parameter int FRAC   = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [$clog2(N_CH)-1:0]  cfg_addr,
    input  logic [GAIN_W-1:0]        cfg_gain,
    input  logic [$clog2(N_CH)-1:0]  rd_ch,
    input  logic [AMP_W-1:0]         rd_amp,
    output logic [AMP_W-1:0]         corr_amp
);
    localparam int PROD_W = AMP_W + GAIN_W;
    localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1 << FRAC);

    logic [GAIN_W-1:0] gain_q [N_CH];
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] scaled;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_CH; i++) gain_q[i] <= UNITY;
        end else if (cfg_we) begin
            gain_q[cfg_addr] <= cfg_gain;
        end
    end

    always_comb begin
        prod     = PROD_W'(rd_amp) * PROD_W'(gain_q[rd_ch]);
        scaled   = prod >> FRAC;
        corr_amp = (scaled > PROD_W'(AMP_MAX)) ? AMP_W'(AMP_MAX) : scaled[AMP_W-1:0];
    end

endmodule

// File: rtl/hitflt_cluster.sv
module hitflt_cluster
    import hitflt_pkg::*;
#(
    parameter int CLUSTER_WIN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  hit_t             in_hit,
    input  logic [AMP_W-1:0] e_lo,
    input  logic [AMP_W-1:0] e_hi,
    output logic             ev_valid,
    input  logic             ev_ready,
    output hit_t             ev_hit,
    output logic             ev_marker
);
    typedef enum logic [1:0] {B_COLLECT, B_EMIT, B_MARK} bstate_t;

    bstate_t          state_q, state_d;
    logic             open_q;
    hit_t             cl_q;
    hit_t             pend_q;
    logic             pend_mark_q;
    logic             in_mark;
    logic             joins;
    logic             energy_ok;
    logic             emit_done;
    logic [TS_W-1:0]  dts;
    logic [AMP_W:0]   sum_w;
    logic [AMP_W-1:0] sum_sat;

    always_comb begin
        in_mark   = in_hit.flags[0];
        dts       = in_hit.ts - cl_q.ts;
        joins     = open_q && (in_hit.id[ID_W-1:CH_W] == cl_q.id[ID_W-1:CH_W])
                    && (dts <= TS_W'(CLUSTER_WIN));
        energy_ok = (cl_q.amp >= e_lo) && (cl_q.amp <= e_hi);
        emit_done = !energy_ok || ev_ready;
        sum_w     = {1'b0, cl_q.amp} + {1'b0, in_hit.amp};
        sum_sat   = sum_w[AMP_W] ? AMP_W'(AMP_MAX) : sum_w[AMP_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= B_COLLECT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            B_COLLECT: if (in_valid) begin
                if (in_mark)              state_d = open_q ? B_EMIT : B_MARK;
                else if (open_q && !joins) state_d = B_EMIT;
            end
            B_EMIT:    if (emit_done) state_d = pend_mark_q ? B_MARK : B_COLLECT;
            B_MARK:    if (ev_ready)  state_d = B_COLLECT;
            default:   state_d = B_COLLECT;
        endcase
    end

    always_comb begin
        in_ready  = (state_q == B_COLLECT);
        ev_valid  = ((state_q == B_EMIT) && energy_ok) || (state_q == B_MARK);
        ev_marker = (state_q == B_MARK);
        ev_hit    = (state_q == B_MARK) ? pend_q : cl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q      <= 1'b0;
            cl_q        <= '0;
            pend_q      <= '0;
            pend_mark_q <= 1'b0;
        end else begin
            unique case (state_q)
                B_COLLECT: if (in_valid) begin
                    if (in_mark) begin
                        pend_q      <= in_hit;
                        pend_mark_q <= 1'b1;
                    end else if (joins) begin
                        cl_q.amp <= sum_sat;
                    end else if (open_q) begin
                        pend_q      <= in_hit;
                        pend_mark_q <= 1'b0;
                    end else begin
                        cl_q   <= in_hit;
                        open_q <= 1'b1;
                    end
                end
                B_EMIT: if (emit_done) begin
                    if (pend_mark_q) open_q <= 1'b0;
                    else             cl_q   <= pend_q;
                end
                B_MARK: if (ev_ready) pend_mark_q <= 1'b0;
                default: ;
            endcase
        end
    end

    AST_SUM_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == B_COLLECT && in_valid && !in_mark && joins) |=> (cl_q.amp >= $past(cl_q.amp))); // R3

endmodule

// File: rtl/hitflt_window.sv
module hitflt_window
    import hitflt_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DROP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    output logic              ev_ready,
    input  hit_t              ev_hit,
    input  logic              ev_marker,
    input  logic [7:0]        coinc_win,
    output logic              out_valid,
    input  logic              out_ready,
    output hit_t              out_data,
    output logic [DROP_W-1:0] drop_count
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef enum logic [1:0] {W_IDLE, W_MATCH, W_RETIRE, W_INSERT} wstate_t;

    wstate_t          state_q, state_d;
    hit_t             ent_q [DEPTH];
    logic [DEPTH-1:0] co_q;
    logic [CNT_W-1:0] cnt_q;
    hit_t             nh_q;
    logic             nm_q;
    logic             nco_q;
    logic [DEPTH-1:0] hitv;
    logic             head_exp;
    logic             pop;
    logic [TS_W-1:0]  head_dts;
    logic [TS_W-1:0]  out_dts;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            logic [TS_W-1:0] d;
            d       = nh_q.ts - ent_q[i].ts;
            hitv[i] = (CNT_W'(i) < cnt_q) && !nm_q
                      && (ent_q[i].id[ID_W-1:CH_W] != nh_q.id[ID_W-1:CH_W])
                      && (d <= TS_W'(coinc_win));
        end
        head_dts = nh_q.ts - ent_q[0].ts;
        head_exp = (cnt_q != '0) && (head_dts > TS_W'(coinc_win));
        pop      = (state_q == W_RETIRE) && head_exp && (!co_q[0] || out_ready);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= W_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_IDLE:   if (ev_valid) state_d = W_MATCH;
            W_MATCH:  state_d = W_RETIRE;
            W_RETIRE: if (!head_exp) state_d = W_INSERT;
            W_INSERT: state_d = W_IDLE;
            default:  state_d = W_IDLE;
        endcase
    end

    always_comb begin
        ev_ready  = (state_q == W_IDLE);
        out_valid = (state_q == W_RETIRE) && head_exp && co_q[0];
        out_data  = ent_q[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
            co_q       <= '0;
            cnt_q      <= '0;
            nh_q       <= '0;
            nm_q       <= 1'b0;
            nco_q      <= 1'b0;
            drop_count <= '0;
        end else begin
            unique case (state_q)
                W_IDLE: if (ev_valid) begin
                    nh_q <= ev_hit;
                    nm_q <= ev_marker;
                end
                W_MATCH: begin
                    co_q  <= co_q | hitv;
                    nco_q <= |hitv;
                end
                W_RETIRE: if (pop) begin
                    for (int i = 0; i < DEPTH - 1; i++) begin
                        ent_q[i] <= ent_q[i+1];
                        co_q[i]  <= co_q[i+1];
                    end
                    co_q[DEPTH-1] <= 1'b0;
                    cnt_q         <= cnt_q - 1'b1;
                end
                W_INSERT: if (!nm_q) begin
                    if (cnt_q == CNT_W'(DEPTH)) begin
                        for (int i = 0; i < DEPTH - 1; i++) begin
                            ent_q[i] <= ent_q[i+1];
                            co_q[i]  <= co_q[i+1];
                        end
                        ent_q[DEPTH-1] <= nh_q;
                        co_q[DEPTH-1]  <= nco_q;
                        drop_count     <= drop_count + 1'b1;
                    end else begin
                        for (int i = 0; i < DEPTH; i++) begin
                            if (CNT_W'(i) == cnt_q) begin
                                ent_q[i] <= nh_q;
                                co_q[i]  <= nco_q;
                            end
                        end
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign out_dts = nh_q.ts - out_data.ts;

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9
    AST_NO_MARKER_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !out_data.flags[0]); // R6
    AST_OUT_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_dts > TS_W'(coinc_win))); // R7
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH)); // R8
    AST_DROP_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count != $past(drop_count)) |-> ($past(cnt_q) == CNT_W'(DEPTH))); // R8

endmodule

// File: rtl/coinc_energy_filter.sv
module coinc_energy_filter
    import hitflt_pkg::*;
#(
    parameter int CLUSTER_WIN = 4,
    parameter int DEPTH       = 8,
    parameter int DROP_W      = 16,
    parameter int N_CH        = 16,
    parameter int GAIN_W      = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [HIT_W-1:0]        in_data,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [HIT_W-1:0]        out_data,
    input  logic                    cfg_we,
    input  logic [$clog2(N_CH)-1:0] cfg_addr,
    input  logic [GAIN_W-1:0]       cfg_gain,
    input  logic [7:0]              coinc_win,
    input  logic [AMP_W-1:0]        e_lo,
    input  logic [AMP_W-1:0]        e_hi,
    output logic [DROP_W-1:0]       drop_count
);
    hit_t             raw_hit;
    hit_t             corr_hit;
    logic [AMP_W-1:0] corr_amp;
    logic             ev_valid;
    logic             ev_ready;
    hit_t             ev_hit;
    logic             ev_marker;
    hit_t             win_out;

    assign raw_hit = hit_t'(in_data);

    hitflt_gain_table #(.N_CH(N_CH), .GAIN_W(GAIN_W), .FRAC(GAIN_W - 2)) gain_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_gain (cfg_gain),
        .rd_ch    (raw_hit.id[$clog2(N_CH)-1:0]),
        .rd_amp   (raw_hit.amp),
        .corr_amp (corr_amp)
    );

    always_comb begin
        corr_hit     = raw_hit;
        corr_hit.amp = corr_amp;
    end

    hitflt_cluster #(.CLUSTER_WIN(CLUSTER_WIN)) clus_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_hit    (corr_hit),
        .e_lo      (e_lo),
        .e_hi      (e_hi),
        .ev_valid  (ev_valid),
        .ev_ready  (ev_ready),
        .ev_hit    (ev_hit),
        .ev_marker (ev_marker)
    );

    hitflt_window #(.DEPTH(DEPTH), .DROP_W(DROP_W)) win_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_valid   (ev_valid),
        .ev_ready   (ev_ready),
        .ev_hit     (ev_hit),
        .ev_marker  (ev_marker),
        .coinc_win  (coinc_win),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (win_out),
        .drop_count (drop_count)
    );

    assign out_data = win_out;

    AST_ENERGY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !ev_marker) |-> (ev_hit.amp >= e_lo && ev_hit.amp <= e_hi)); // R4

endmodule

// File: tb/coinc_energy_filter_tb_top.sv
module coinc_energy_filter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [47:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [47:0] out_data;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [7:0]  cfg_gain = '0;
    logic [7:0]  coinc_win = 8'd10;
    logic [8:0]  e_lo = 9'd100;
    logic [8:0]  e_hi = 9'd400;
    logic [15:0] drop_count;

    int checks = 0;
    int errors = 0;
    logic [47:0] cap [32];
    int cap_n = 0;

    always #2 clk = ~clk;

    coinc_energy_filter dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_gain(cfg_gain), .coinc_win(coinc_win), .e_lo(e_lo), .e_hi(e_hi),
        .drop_count(drop_count)
    );

    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready && cap_n < 32) begin
            cap[cap_n] = out_data;
            cap_n++;
        end
    end

    function automatic logic [47:0] mk(input int ts, input logic [7:0] id, input int amp, input logic [6:0] fl);
        return {24'(ts), id, 9'(amp), fl};
    endfunction

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input int ts, input logic [7:0] id, input int amp, input logic [6:0] fl);
        @(negedge clk);
        in_data  = mk(ts, id, amp, fl);
        in_valid = 1'b1;
        forever begin
            if (in_ready) begin
                @(posedge clk);
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic flush(input int ts);
        send(ts, 8'h00, 0, 7'h01);
        repeat (40) @(negedge clk);
    endtask

    task automatic set_gain(input logic [3:0] ch, input logic [7:0] g);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = ch; cfg_gain = g;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic t_reset;
        chk("R10 out_valid", 48'(out_valid), 48'd0);
        chk("R10 drop_count", 48'(drop_count), 48'd0);
        chk("R10 in_ready", 48'(in_ready), 48'd1);
    endtask

    task automatic t_pair;
        cap_n = 0;
        send(100, 8'h10, 200, 0);
        send(105, 8'h20, 300, 0);
        flush(1100);
        chk("R5 pair count", 48'(cap_n), 48'd2);
        chk("R7 R1 first", cap[0], mk(100, 8'h10, 200, 0));
        chk("R7 R1 second", cap[1], mk(105, 8'h20, 300, 0));
    endtask

    task automatic t_singles;
        cap_n = 0;
        send(2000, 8'h10, 200, 0);
        send(2050, 8'h20, 200, 0);
        flush(3000);
        chk("R5 singles dropped", 48'(cap_n), 48'd0);
        cap_n = 0;
        send(4000, 8'h10, 200, 0);
        send(4008, 8'h11, 200, 0);
        flush(5000);
        chk("R5 same chip no pair", 48'(cap_n), 48'd0);
    endtask

    task automatic t_cluster;
        cap_n = 0;
        send(6000, 8'h10, 100, 0);
        send(6002, 8'h11, 150, 0);
        send(6006, 8'h20, 200, 0);
        flush(7000);
        chk("R3 cluster count", 48'(cap_n), 48'd2);
        chk("R3 cluster sum", cap[0], mk(6000, 8'h10, 250, 0));
        chk("R3 partner", cap[1], mk(6006, 8'h20, 200, 0));
    endtask

    task automatic t_energy;
        cap_n = 0;
        send(8000, 8'h10, 50, 0);
        send(8003, 8'h20, 200, 0);
        flush(9000);
        chk("R4 low cut", 48'(cap_n), 48'd0);
        cap_n = 0;
        send(10000, 8'h10, 450, 0);
        send(10003, 8'h20, 200, 0);
        flush(11000);
        chk("R4 high cut", 48'(cap_n), 48'd0);
        cap_n = 0;
        send(12000, 8'h10, 100, 0);
        send(12003, 8'h20, 400, 0);
        flush(13000);
        chk("R4 inclusive bounds", 48'(cap_n), 48'd2);
        chk("R4 upper bound kept", cap[1], mk(12003, 8'h20, 400, 0));
    endtask

    task automatic t_gain;
        set_gain(4'd3, 8'd128);
        cap_n = 0;
        send(14000, 8'h13, 150, 0);
        send(14004, 8'h20, 200, 0);
        flush(15000);
        chk("R2 gain x2", cap[0], mk(14000, 8'h13, 300, 0));
        set_gain(4'd3, 8'd255);
        e_hi = 9'd511;
        cap_n = 0;
        send(16000, 8'h13, 400, 0);
        send(16004, 8'h20, 200, 0);
        flush(17000);
        chk("R2 saturation", cap[0], mk(16000, 8'h13, 511, 0));
        e_hi = 9'd400;
        set_gain(4'd3, 8'd64);
    endtask

    task automatic t_edge;
        cap_n = 0;
        send(18000, 8'h10, 200, 0);
        send(18010, 8'h20, 200, 0);
        flush(19000);
        chk("R5 diff equals window", 48'(cap_n), 48'd2);
        cap_n = 0;
        send(20000, 8'h10, 200, 0);
        send(20011, 8'h20, 200, 0);
        flush(21000);
        chk("R5 diff beyond window", 48'(cap_n), 48'd0);
    endtask

    task automatic t_timeout;
        cap_n = 0;
        flush(22000);
        chk("R6 lone marker", 48'(cap_n), 48'd0);
        cap_n = 0;
        send(23000, 8'h10, 100, 0);
        send(23001, 8'h30, 300, 7'h01);
        send(23002, 8'h10, 150, 0);
        send(23005, 8'h20, 200, 0);
        flush(24000);
        chk("R6 marker splits cluster", 48'(cap_n), 48'd3);
        chk("R6 first part", cap[0], mk(23000, 8'h10, 100, 0));
        chk("R6 second part", cap[1], mk(23002, 8'h10, 150, 0));
        chk("R6 partner", cap[2], mk(23005, 8'h20, 200, 0));
    endtask

    task automatic t_overflow;
        coinc_win = 8'd255;
        cap_n = 0;
        for (int k = 0; k < 9; k++) send(30000 + 6 * k, (k % 2 == 0) ? 8'h10 : 8'h20, 200, 0);
        flush(31000);
        chk("R8 drop_count", 48'(drop_count), 48'd1);
        chk("R8 survivors", 48'(cap_n), 48'd8);
        chk("R8 oldest evicted", cap[0], mk(30006, 8'h20, 200, 0));
        chk("R8 newest kept", cap[7], mk(30048, 8'h10, 200, 0));
        coinc_win = 8'd10;
    endtask

    task automatic t_backpressure;
        cap_n = 0;
        out_ready = 1'b0;
        send(40000, 8'h10, 200, 0);
        send(40005, 8'h20, 300, 0);
        send(41000, 8'h00, 0, 7'h01);
        repeat (30) @(negedge clk);
        chk("R9 valid held", 48'(out_valid), 48'd1);
        chk("R9 data held", out_data, mk(40000, 8'h10, 200, 0));
        repeat (5) @(negedge clk);
        chk("R9 data still held", out_data, mk(40000, 8'h10, 200, 0));
        out_ready = 1'b1;
        repeat (20) @(negedge clk);
        chk("R9 both delivered", 48'(cap_n), 48'd2);
        chk("R9 second word", cap[1], mk(40005, 8'h20, 300, 0));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_pair();
        t_singles();
        t_cluster();
        t_energy();
        t_gain();
        t_edge();
        t_timeout();
        t_overflow();
        t_backpressure();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule